// File: doc/BRIEF.md
# I2C Serial EEPROM Controller With Page Write

This block is the bus-facing half of a 256-byte nonvolatile memory. It is an I2C slave. The array itself is modelled as a register array, and programming is modelled as a fixed delay counted in clock cycles. A master sends a device address, then a one-byte word address, then data bytes. The controller collects up to one four-byte page in a buffer. At the closing stop condition it launches a self-timed write cycle, and the page is committed to the array when that cycle ends. Reads return the byte at the internal pointer and move the pointer on. The pointer serves three kinds of read: a random read (word address, repeated start, read), a current-address read, and an open-ended sequential read.

SCL and SDA are sampled on the system clock through a synchronizer. Start, stop and clock edges are then detected from the sampled levels. SDA is open drain: `sda_oe` high means the block pulls the line low. No data stream crosses the block edge apart from the bus itself. The master sets the pace through SCL and applies back-pressure only by holding SCL low. While a write cycle is running, the block applies its own back-pressure by refusing to acknowledge its address. A write-control pin held high lets a transfer run to the end but stops any programming.

Top module: `i2c_page_eeprom`

## Requirements
- R1: The device address byte has bits[7:4] = 4'b1010, bits[3:1] = the strap pins and bit 0 = R/W (1 = read). The block acknowledges only a byte matching its own prefix and strap value. Any other address leaves SDA released and is ignored until the next start.
- R2: In a write transfer, the first byte after the device address is acknowledged and loads the 8-bit address pointer.
- R3: Each following data byte is acknowledged and stored in the page buffer slot given by the pointer's low 2 bits. Those 2 bits then increment and wrap within the four-byte page; bits [7:2] are unchanged. A fifth and later byte overwrites earlier slots.
- R4: A stop after at least one data byte, with write control low, raises `busy_o` for exactly WR_CYCLES clock cycles. The stored bytes reach the array when the cycle ends.
- R5: While `busy_o` is high, the block does not acknowledge its device address.
- R6: With write control high at the stop, data bytes are still acknowledged, but no write cycle starts and the array keeps its contents.
- R7: A read returns the byte at the pointer and then increments the pointer, wrapping from 255 to 0. A master acknowledge asks for the next byte. A master not-acknowledge ends the read, and SDA stays released.
- R8: A current-address read (device address with R/W = 1, no word address) starts at the pointer as the previous transfer left it. After a page write, that is the page-wrapped position.
- R9: A device address and word address for write, then a repeated start and a device address for read, returns data from the word address just loaded.
- R10: A stop that follows no data byte, or a repeated start, starts no write cycle. Bytes already buffered are discarded.
- R11: After reset, SDA is released, `busy_o` is low and every array byte reads 0.
- R12: `sda_oe` changes only while sampled SCL is low, except when a start or stop forces a release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level as seen on the wire |
| sda_oe | output | 1 | 1 pulls SDA low |
| strap_i | input | 3 | Device address strap bits |
| wc_i | input | 1 | Write control; high blocks programming |
| busy_o | output | 1 | Self-timed write cycle in progress |

## Verification
The assertions check four things on every cycle. First, a write cycle starts only at a stop with write control low, and it lasts exactly WR_CYCLES cycles. Second, no device-address acknowledge occurs while busy. Third, SDA is released whenever the protocol engine is idle. Fourth, `sda_oe` moves only while SCL is low. Other properties need whole transfers and are shown only by the bench scenarios: page wrap and overwrite, the pointer wrap at 255, current-address and random reads, the write-control block, and the discarding of bytes on a repeated start. The bench also sweeps all 128 device addresses against the strap.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam int BYTE_W = 8;
  localparam logic [3:0] DEV_PREFIX = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACKO, ST_TX, ST_ACKI
  } bus_st_t;

  typedef enum logic [1:0] {
    K_DEV, K_WADDR, K_WDATA
  } kind_t;
endpackage

// File: rtl/i2c_cond_det.sv
module i2c_cond_det #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [SYNC_N-1:0] scl_sy, sda_sy;
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_sy <= '1;
      sda_sy <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[SYNC_N-2:0], scl_i};
      sda_sy <= {sda_sy[SYNC_N-2:0], sda_i};
      scl_q  <= scl_sy[SYNC_N-1];
      sda_q  <= sda_sy[SYNC_N-1];
    end
  end

  assign scl_s     = scl_sy[SYNC_N-1];
  assign sda_s     = sda_sy[SYNC_N-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/eep_wr_timer.sv
module eep_wr_timer #(
  parameter int WR_CYCLES = 1250000,
  parameter int PAGE_W    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic [eep_pkg::BYTE_W-PAGE_W-1:0] page_in,
  input  logic [(1<<PAGE_W)-1:0] mask_in,
  input  logic [(1<<PAGE_W)-1:0][eep_pkg::BYTE_W-1:0] data_in,
  output logic busy,
  output logic commit,
  output logic [eep_pkg::BYTE_W-PAGE_W-1:0] pend_page,
  output logic [(1<<PAGE_W)-1:0] pend_mask,
  output logic [(1<<PAGE_W)-1:0][eep_pkg::BYTE_W-1:0] pend_data
);
  localparam int CNT_W = $clog2(WR_CYCLES + 1);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      cnt       <= '0;
      pend_page <= '0;
      pend_mask <= '0;
      pend_data <= '0;
    end else if (go && !busy) begin
      busy      <= 1'b1;
      cnt       <= CNT_W'(WR_CYCLES - 1);
      pend_page <= page_in;
      pend_mask <= mask_in;
      pend_data <= data_in;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  assign commit = busy && (cnt == '0);
endmodule

// File: rtl/eep_array.sv
module eep_array #(
  parameter int PAGE_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic [eep_pkg::BYTE_W-1:0] raddr,
  output logic [eep_pkg::BYTE_W-1:0] rdata,
  input  logic commit,
  input  logic [eep_pkg::BYTE_W-PAGE_W-1:0] page,
  input  logic [(1<<PAGE_W)-1:0] mask,
  input  logic [(1<<PAGE_W)-1:0][eep_pkg::BYTE_W-1:0] data
);
  localparam int DEPTH = 1 << eep_pkg::BYTE_W;
  localparam int PAGE_BYTES = 1 << PAGE_W;
  logic [eep_pkg::BYTE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int a = 0; a < DEPTH; a++) mem[a] <= '0;
    end else if (commit) begin
      for (int i = 0; i < PAGE_BYTES; i++)
        if (mask[i]) mem[{page, PAGE_W'(i)}] <= data[i];
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/eep_bus_core.sv
module eep_bus_core
  import eep_pkg::*;
#(
  parameter int PAGE_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sda_s,
  input  logic scl_rise,
  input  logic scl_fall,
  input  logic start_evt,
  input  logic stop_evt,
  input  logic [2:0] strap_i,
  input  logic wc_i,
  input  logic busy,
  input  logic [BYTE_W-1:0] rdata,
  output logic [BYTE_W-1:0] ptr_q,
  output logic sda_oe,
  output logic go,
  output logic [(1<<PAGE_W)-1:0] vmask,
  output logic [(1<<PAGE_W)-1:0][BYTE_W-1:0] pbuf,
  output bus_st_t st_o,
  output kind_t kind_o
);
  bus_st_t st;
  kind_t   kind;
  logic [3:0] bit_cnt;
  logic [BYTE_W-1:0] shreg;
  logic rw, mack;

  assign go     = stop_evt && (|vmask) && !wc_i && !busy;
  assign st_o   = st;
  assign kind_o = kind;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      kind    <= K_DEV;
      bit_cnt <= '0;
      shreg   <= '0;
      rw      <= 1'b0;
      mack    <= 1'b0;
      ptr_q   <= '0;
      sda_oe  <= 1'b0;
      vmask   <= '0;
      pbuf    <= '0;
    end else if (start_evt) begin
      st      <= ST_RX;
      kind    <= K_DEV;
      bit_cnt <= '0;
      sda_oe  <= 1'b0;
      vmask   <= '0;
    end else if (stop_evt) begin
      st     <= ST_IDLE;
      sda_oe <= 1'b0;
      vmask  <= '0;
    end else begin
      unique case (st)
        ST_RX: begin
          if (scl_rise) begin
            shreg   <= {shreg[BYTE_W-2:0], sda_s};
            bit_cnt <= bit_cnt + 4'd1;
          end else if (scl_fall && bit_cnt == 4'd8) begin
            bit_cnt <= '0;
            unique case (kind)
              K_DEV: begin
                if (shreg[7:1] == {DEV_PREFIX, strap_i} && !busy) begin
                  sda_oe <= 1'b1;
                  rw     <= shreg[0];
                  st     <= ST_ACKO;
                end else begin
                  st <= ST_IDLE;
                end
              end
              K_WADDR: begin
                ptr_q  <= shreg;
                sda_oe <= 1'b1;
                st     <= ST_ACKO;
              end
              default: begin
                pbuf[ptr_q[PAGE_W-1:0]]  <= shreg;
                vmask[ptr_q[PAGE_W-1:0]] <= 1'b1;
                ptr_q[PAGE_W-1:0]        <= ptr_q[PAGE_W-1:0] + PAGE_W'(1);
                sda_oe <= 1'b1;
                st     <= ST_ACKO;
              end
            endcase
          end
        end
        ST_ACKO: begin
          if (scl_fall) begin
            bit_cnt <= '0;
            if (kind == K_DEV && rw) begin
              shreg  <= rdata;
              sda_oe <= ~rdata[BYTE_W-1];
              ptr_q  <= ptr_q + 1'b1;
              st     <= ST_TX;
            end else begin
              sda_oe <= 1'b0;
              kind   <= (kind == K_DEV) ? K_WADDR : K_WDATA;
              st     <= ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bit_cnt == 4'd7) begin
              sda_oe <= 1'b0;
              st     <= ST_ACKI;
            end else begin
              shreg   <= {shreg[BYTE_W-2:0], 1'b0};
              sda_oe  <= ~shreg[BYTE_W-2];
              bit_cnt <= bit_cnt + 4'd1;
            end
          end
        end
        ST_ACKI: begin
          if (scl_rise) begin
            mack <= ~sda_s;
          end else if (scl_fall) begin
            if (mack) begin
              shreg   <= rdata;
              sda_oe  <= ~rdata[BYTE_W-1];
              ptr_q   <= ptr_q + 1'b1;
              bit_cnt <= '0;
              st      <= ST_TX;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_page_eeprom.sv
module i2c_page_eeprom
  import eep_pkg::*;
#(
  parameter int WR_CYCLES = 1250000,
  parameter int PAGE_W    = 2,
  parameter int SYNC_N    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [2:0] strap_i,
  input  logic       wc_i,
  output logic       busy_o
);
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int PAGE_AW    = BYTE_W - PAGE_W;

  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic go, commit;
  logic [BYTE_W-1:0] ptr, rdata;
  logic [PAGE_BYTES-1:0] vmask, pend_mask;
  logic [PAGE_BYTES-1:0][BYTE_W-1:0] pbuf, pend_data;
  logic [PAGE_AW-1:0] pend_page;
  bus_st_t bus_st;
  kind_t   bus_kind;

  i2c_cond_det #(.SYNC_N(SYNC_N)) u_det (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  eep_bus_core #(.PAGE_W(PAGE_W)) u_core (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt),
    .strap_i(strap_i), .wc_i(wc_i), .busy(busy_o), .rdata(rdata),
    .ptr_q(ptr), .sda_oe(sda_oe), .go(go), .vmask(vmask), .pbuf(pbuf),
    .st_o(bus_st), .kind_o(bus_kind)
  );

  eep_wr_timer #(.WR_CYCLES(WR_CYCLES), .PAGE_W(PAGE_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .go(go), .page_in(ptr[BYTE_W-1:PAGE_W]),
    .mask_in(vmask), .data_in(pbuf), .busy(busy_o), .commit(commit),
    .pend_page(pend_page), .pend_mask(pend_mask), .pend_data(pend_data)
  );

  eep_array #(.PAGE_W(PAGE_W)) u_arr (
    .clk(clk), .rst_n(rst_n), .raddr(ptr), .rdata(rdata),
    .commit(commit), .page(pend_page), .mask(pend_mask), .data(pend_data)
  );
endmodule

// File: rtl/eep_chk.sv
module eep_chk
  import eep_pkg::*;
#(
  parameter int WR_CYCLES = 1250000
) (
  input logic    clk,
  input logic    rst_n,
  input logic    sda_oe,
  input logic    busy_o,
  input logic    wc_i,
  input logic    scl_s,
  input logic    start_evt,
  input logic    stop_evt,
  input bus_st_t st,
  input kind_t   kind
);
  logic [31:0] bcnt;

  always_ff @(posedge clk) begin
    if (!rst_n)      bcnt <= '0;
    else if (busy_o) bcnt <= bcnt + 1'b1;
    else             bcnt <= '0;
  end

  // R4: a cycle begins only at a stop with write control low
  p_busy_launch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(stop_evt && !wc_i));

  // R4: the cycle length is fixed
  p_busy_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (bcnt == 32'(WR_CYCLES)));

  // R5: no address acknowledge during a write cycle
  p_busy_nack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !(st == ST_ACKO && kind == K_DEV));

  // R7: an idle engine never holds SDA
  p_idle_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !sda_oe);

  // R12: SDA moves only while SCL is low, or on a forced release
  p_sda_scl_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> $past(!scl_s || start_evt || stop_evt));
endmodule

bind i2c_page_eeprom eep_chk #(.WR_CYCLES(WR_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .busy_o(busy_o), .wc_i(wc_i),
  .scl_s(scl_s), .start_evt(start_evt), .stop_evt(stop_evt),
  .st(bus_st), .kind(bus_kind)
);

// File: tb/test_i2c_page_eeprom.sv
module test_i2c_page_eeprom;
  localparam int WRC = 400;
  localparam int P   = 8;
  localparam logic [2:0] STRAP = 3'd5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, busy_o, wc = 1'b0;
  logic [2:0] strap = STRAP;
  logic sda_line;
  int checks = 0, errors = 0, busy_run = 0;
  bit finished = 0;

  assign sda_line = sda_m & ~sda_oe;
  always #2 clk = ~clk;
  always @(negedge clk) if (busy_o) busy_run++;

  i2c_page_eeprom #(.WR_CYCLES(WRC)) i_i2c_page_eeprom (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .strap_i(strap), .wc_i(wc), .busy_o(busy_o)
  );

  function automatic logic [7:0] dval(int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic i2c_start();
    sda_m = 1; tick(P); scl_m = 1; tick(P); sda_m = 0; tick(P); scl_m = 0; tick(P);
  endtask

  task automatic i2c_stop();
    sda_m = 0; tick(P); scl_m = 1; tick(P); sda_m = 1; tick(P);
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(P); scl_m = 1; tick(P); scl_m = 0; tick(1);
    end
    sda_m = 1; tick(P); scl_m = 1; tick(P/2); ack = ~sda_line;
    tick(P/2); scl_m = 0; tick(1);
  endtask

  task automatic rd_byte(input logic mack, output logic [7:0] b);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      tick(P); scl_m = 1; tick(P/2); b[i] = sda_line; tick(P/2); scl_m = 0; tick(1);
    end
    sda_m = ~mack; tick(P); scl_m = 1; tick(P); scl_m = 0; tick(1);
  endtask

  function automatic logic [7:0] dev(logic rd);
    return {4'b1010, STRAP, rd};
  endfunction

  task automatic page_write(input logic [7:0] a, input logic [7:0] d [8], input int n);
    logic ack;
    i2c_start(); wr_byte(dev(0), ack); wr_byte(a, ack);
    for (int k = 0; k < n; k++) wr_byte(d[k], ack);
    i2c_stop();
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy_o && n < 4 * WRC) begin tick(1); n++; end
  endtask

  task automatic rand_read(input logic [7:0] a, input int n, output logic [7:0] q [8]);
    logic ack;
    i2c_start(); wr_byte(dev(0), ack); wr_byte(a, ack);
    i2c_start(); wr_byte(dev(1), ack);
    for (int k = 0; k < n; k++) rd_byte(k < n - 1, q[k]);
    i2c_stop();
  endtask

  initial begin
    logic ack;
    logic [7:0] d [8];
    logic [7:0] q [8];
    logic [7:0] rb;
    tick(5); rst_n = 1; tick(5);

    // R11: reset state
    chk("R11 sda_oe", int'(sda_oe), 0);
    chk("R11 busy", int'(busy_o), 0);
    rand_read(8'h80, 2, q);
    chk("R11 array zero", int'(q[0]), 0);
    chk("R11 array zero", int'(q[1]), 0);

    // R1: sweep all write-direction device addresses
    for (int a = 0; a < 128; a++) begin
      i2c_start(); wr_byte({7'(a), 1'b0}, ack); i2c_stop();
      chk("R1 address match", int'(ack), int'(a == {4'b1010, STRAP}));
    end
    strap = 3'd3;
    i2c_start(); wr_byte(8'hA6, ack); i2c_stop();
    chk("R1 strap 3", int'(ack), 1);
    strap = STRAP;

    // R10: stop after only a word address
    i2c_start(); wr_byte(dev(0), ack); wr_byte(8'h50, ack); i2c_stop(); tick(4);
    chk("R10 no data no cycle", int'(busy_o), 0);

    // R2 R3 R4 R5 R8 R9: page write of four bytes at 0x10
    for (int k = 0; k < 4; k++) d[k] = dval(16 + k);
    busy_run = 0;
    page_write(8'h10, d, 4);
    chk("R4 busy after stop", int'(busy_o), 1);
    i2c_start(); wr_byte(dev(0), ack); i2c_stop();
    chk("R5 nack while busy", int'(ack), 0);
    wait_idle(); tick(2);
    chk("R4 cycle length", busy_run, WRC);
    i2c_start(); wr_byte(dev(1), ack); rd_byte(0, rb); i2c_stop();
    chk("R8 current read after page write", int'(rb), int'(dval(16)));
    rand_read(8'h10, 4, q);
    for (int k = 0; k < 4; k++) chk("R9 R2 random read", int'(q[k]), int'(dval(16 + k)));

    // R3: six bytes from 0x22 wrap in the page
    for (int k = 0; k < 6; k++) d[k] = dval(128 + k);
    page_write(8'h22, d, 6); wait_idle(); tick(2);
    rand_read(8'h20, 5, q);
    chk("R3 wrap 0x20", int'(q[0]), int'(dval(130)));
    chk("R3 wrap 0x21", int'(q[1]), int'(dval(131)));
    chk("R3 wrap 0x22", int'(q[2]), int'(dval(132)));
    chk("R3 wrap 0x23", int'(q[3]), int'(dval(133)));
    chk("R3 next page untouched", int'(q[4]), 0);

    // R6: write control high
    wc = 1;
    i2c_start(); wr_byte(dev(0), ack); wr_byte(8'h30, ack); wr_byte(8'h5A, ack);
    chk("R6 data acked", int'(ack), 1);
    i2c_stop(); tick(4);
    chk("R6 no cycle", int'(busy_o), 0);
    wc = 0;
    rand_read(8'h30, 1, q);
    chk("R6 array unchanged", int'(q[0]), 0);

    // R10: repeated start discards buffered byte
    i2c_start(); wr_byte(dev(0), ack); wr_byte(8'h40, ack); wr_byte(8'h77, ack);
    i2c_start(); wr_byte(dev(1), ack); rd_byte(0, rb); i2c_stop(); tick(4);
    chk("R10 read from wrapped pointer", int'(rb), 0);
    chk("R10 no cycle", int'(busy_o), 0);
    rand_read(8'h40, 1, q);
    chk("R10 byte discarded", int'(q[0]), 0);

    // R7: sequential read across 255 -> 0
    for (int k = 0; k < 4; k++) d[k] = dval(252 + k);
    page_write(8'hFC, d, 4); wait_idle(); tick(2);
    d[0] = 8'hC3;
    page_write(8'h00, d, 1); wait_idle(); tick(2);
    rand_read(8'hFE, 3, q);
    chk("R7 read 0xFE", int'(q[0]), int'(dval(254)));
    chk("R7 read 0xFF", int'(q[1]), int'(dval(255)));
    chk("R7 wrap to 0x00", int'(q[2]), 8'hC3);
    i2c_start(); wr_byte(dev(1), ack); rd_byte(0, rb);
    chk("R7 released after nack", int'(sda_oe), 0);
    i2c_stop();
    chk("R8 current read continues at 0x01", int'(rb), 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule